// File: doc/BRIEF.md
# Soft Multi-Port Bank Access Scheduler

This block sits between a small set of processing-element load/store requesters and a group of single-ported memory banks. A bank can work on only one row at a time. Each requester presents at most one request per cycle, naming a bank and a row. Requests that name different free banks all start in the same cycle. Requests that name the same bank are taken one at a time, lowest requester index first. A requester keeps its request on the inputs until it sees its accept pulse.

Every access takes a fixed number of logic cycles, five by default. The result comes back to the requester that issued it, as a one-cycle completion pulse that carries the read data for a load. The banks are plain behavioural register arrays, cleared at reset.

A scoreboard keeps one pending bit per destination register of the issuing controller. It lets the controller go on issuing work while loads are still in flight. A stall output is raised only when the instruction being checked reads a register whose load has not yet completed.

Top module: `smp_bank_sched`

## Requirements
- R1: While reset is low, and just after it is released, every accept, done, bank-busy, busy and stall output is low and every bank word reads as zero.
- R2: Requests from different requesters to different free banks are all accepted in the same cycle.
- R3: When several valid requests name the same free bank, only the lowest-indexed requester is accepted that cycle. The others stay unaccepted while they hold their requests.
- R4: A valid request to a free bank is accepted combinationally in the cycle it is presented.
- R5: The requester's done output pulses for exactly one cycle, LAT cycles (default 5) after the cycle of its accept.
- R6: A bank's busy bit is high in cycles 1 to LAT after an accept to it. The bank accepts nothing while busy, so the earliest following accept comes LAT+1 cycles after the previous one.
- R7: The store data is written at the completion cycle (write flag 1). A load (write flag 0) returns, on its done cycle, the word held at its bank and row in that cycle. The read data output is zero in every other cycle and on the completion of a store.
- R8: busy is high exactly when at least one bank busy bit is high.
- R9: An accepted load marks its destination register pending from the next cycle through its done cycle. stall equals check-valid AND (source A pending OR source B pending). If a pending bit is cleared by a completion and set by a newly accepted load in the same cycle, the bit stays set.
- R10: stall is low in every cycle where check-valid is low.
- R11: An accepted store does not mark its destination field pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_write | input | NREQ | 1 = store, 0 = load, per requester |
| req_bank | input | NREQ*BW | Target bank index, requester i in bits [i*BW +: BW] |
| req_row | input | NREQ*RW | Target row, requester i in bits [i*RW +: RW] |
| req_wdata | input | NREQ*DW | Store data per requester |
| req_dst | input | NREQ*GW | Destination register index of a load |
| req_accept | output | NREQ | One-cycle accept pulse per requester |
| rsp_done | output | NREQ | Completion pulse per requester |
| rsp_rdata | output | NREQ*DW | Load data, valid with rsp_done |
| bank_busy | output | NBANK | Per-bank access in flight |
| busy | output | 1 | Any bank busy |
| chk_valid | input | 1 | An instruction is being checked for hazards |
| chk_src_a | input | GW | First source register of that instruction |
| chk_src_b | input | GW | Second source register of that instruction |
| stall | output | 1 | Checked instruction reads a pending register |

## Verification
Two things can happen to the same pending bit in one cycle. A load completion clears it, and a fresh load to that same destination, accepted on another bank, sets it again. The bench provokes this by timing the second load to arrive exactly in the first load's done cycle. The bench judges it by stall staying high in the following cycles, as the reference model predicts. A second overlap is a completion on a bank and a waiting request to that same bank. The waiting request must not be accepted until the cycle after the completion, and the model checks the accept timing for this every cycle.

// File: rtl/smp_pkg.sv
// Package: shared defaults and the access-kind type for the bank scheduler.
// Assumes bank, row, register and requester counts are powers of two.
package smp_pkg;
    localparam int unsigned DEF_REQS   = 4;
    localparam int unsigned DEF_BANKS  = 4;
    localparam int unsigned DEF_ROWS   = 8;
    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned DEF_REGS   = 8;
    localparam int unsigned DEF_LAT    = 5;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } op_e;
endpackage

// File: rtl/smp_arbiter.sv
// Per-bank fixed-priority selection. For each free bank it picks the
// lowest-indexed valid requester that names that bank. Purely combinational.
// Assumes NBANK is a power of two, so every bank index is in range.
module smp_arbiter #(
    parameter int NREQ  = 4,
    parameter int NBANK = 4,
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic [NREQ-1:0]  valid,
    input  logic [BW-1:0]    bank [NREQ],
    input  logic [NBANK-1:0] busy,
    output logic [NREQ-1:0]  accept,
    output logic [NBANK-1:0] go,
    output logic [IW-1:0]    who [NBANK]
);
    // Choose a winner per bank; a descending scan leaves the lowest index last.
    always_comb begin
        go = '0;
        for (int b = 0; b < NBANK; b++) begin
            who[b] = '0;
            for (int i = NREQ - 1; i >= 0; i--) begin
                if (valid[i] && (bank[i] == BW'(b)) && !busy[b]) begin
                    go[b]  = 1'b1;
                    who[b] = IW'(i);
                end
            end
        end
    end

    // Tell each requester whether it won the bank it asked for.
    always_comb begin
        for (int i = 0; i < NREQ; i++) begin
            accept[i] = valid[i] && go[bank[i]] && (who[bank[i]] == IW'(i));
        end
    end
endmodule

// File: rtl/smp_bank_unit.sv
// One single-ported bank: a register array plus a fixed-latency access timer.
// A start captures the request; the access completes LAT cycles later,
// when a store writes and a load presents its word. Assumes start is only
// given while the bank is idle and that ROWS is a power of two.
module smp_bank_unit
    import smp_pkg::*;
#(
    parameter int NREQ = 4,
    parameter int ROWS = 8,
    parameter int DW   = 16,
    parameter int NREG = 8,
    parameter int LAT  = 5,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int GW = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int CW = $clog2(LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] st_who,
    input  op_e           st_op,
    input  logic [RW-1:0] st_row,
    input  logic [DW-1:0] st_wdata,
    input  logic [GW-1:0] st_dst,
    output logic          busy,
    output logic          fin,
    output logic [IW-1:0] fin_who,
    output logic          fin_load,
    output logic [GW-1:0] fin_dst,
    output logic [DW-1:0] fin_rdata
);
    logic [CW-1:0] cnt;
    logic [DW-1:0] mem [ROWS];
    logic [IW-1:0] who_q;
    op_e           op_q;
    logic [RW-1:0] row_q;
    logic [DW-1:0] wdata_q;
    logic [GW-1:0] dst_q;

    // Run the access timer and capture the request fields on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            who_q   <= '0;
            op_q    <= OP_LOAD;
            row_q   <= '0;
            wdata_q <= '0;
            dst_q   <= '0;
        end else if (start) begin
            cnt     <= CW'(LAT);
            who_q   <= st_who;
            op_q    <= st_op;
            row_q   <= st_row;
            wdata_q <= st_wdata;
            dst_q   <= st_dst;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    // Hold the bank contents; a store lands in its completion cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
        end else if (fin && (op_q == OP_STORE)) begin
            mem[row_q] <= wdata_q;
        end
    end

    assign busy      = (cnt != '0);
    assign fin       = (cnt == CW'(1));
    assign fin_who   = who_q;
    assign fin_load  = fin && (op_q == OP_LOAD);
    assign fin_dst   = dst_q;
    assign fin_rdata = fin_load ? mem[row_q] : '0;
endmodule

// File: rtl/smp_pend_board.sv
// Pending-destination scoreboard. An accepted load sets a bit and a load
// completion clears it; a set in the same cycle wins. The stall output
// compares the checked sources against the registered bits.
// Assumes NREG is a power of two.
module smp_pend_board #(
    parameter int NREQ  = 4,
    parameter int NBANK = 4,
    parameter int NREG  = 8,
    localparam int GW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREQ-1:0]  set_en,
    input  logic [GW-1:0]    set_idx [NREQ],
    input  logic [NBANK-1:0] clr_en,
    input  logic [GW-1:0]    clr_idx [NBANK],
    input  logic             chk_valid,
    input  logic [GW-1:0]    chk_src_a,
    input  logic [GW-1:0]    chk_src_b,
    output logic             stall
);
    logic [NREG-1:0] pend;
    logic [NREG-1:0] pend_nxt;

    // Apply completions first, then new loads, so a same-cycle set survives.
    always_comb begin
        pend_nxt = pend;
        for (int b = 0; b < NBANK; b++) begin
            if (clr_en[b]) pend_nxt[clr_idx[b]] = 1'b0;
        end
        for (int i = 0; i < NREQ; i++) begin
            if (set_en[i]) pend_nxt[set_idx[i]] = 1'b1;
        end
    end

    // Register the pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nxt;
    end

    assign stall = chk_valid && (pend[chk_src_a] || pend[chk_src_b]);
endmodule

// File: rtl/smp_bank_sched.sv
// Top of the soft multi-port bank scheduler. It unpacks the requester buses,
// arbitrates each bank, runs one timer per bank, routes each completion back
// to the requester that issued it, and keeps the load scoreboard.
// Assumes requesters hold a request until accepted.
module smp_bank_sched
    import smp_pkg::*;
#(
    parameter int NREQ  = DEF_REQS,
    parameter int NBANK = DEF_BANKS,
    parameter int ROWS  = DEF_ROWS,
    parameter int DW    = DEF_DATA_W,
    parameter int NREG  = DEF_REGS,
    parameter int LAT   = DEF_LAT,
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int GW = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREQ-1:0]   req_valid,
    input  logic [NREQ-1:0]   req_write,
    input  logic [NREQ*BW-1:0] req_bank,
    input  logic [NREQ*RW-1:0] req_row,
    input  logic [NREQ*DW-1:0] req_wdata,
    input  logic [NREQ*GW-1:0] req_dst,
    output logic [NREQ-1:0]   req_accept,
    output logic [NREQ-1:0]   rsp_done,
    output logic [NREQ*DW-1:0] rsp_rdata,
    output logic [NBANK-1:0]  bank_busy,
    output logic              busy,
    input  logic              chk_valid,
    input  logic [GW-1:0]     chk_src_a,
    input  logic [GW-1:0]     chk_src_b,
    output logic              stall
);
    logic [BW-1:0] r_bank  [NREQ];
    logic [RW-1:0] r_row   [NREQ];
    logic [DW-1:0] r_wdata [NREQ];
    logic [GW-1:0] r_dst   [NREQ];
    logic [DW-1:0] r_rdata [NREQ];

    logic [NBANK-1:0] go;
    logic [IW-1:0]    who       [NBANK];
    logic [NBANK-1:0] fin;
    logic [IW-1:0]    fin_who   [NBANK];
    logic [NBANK-1:0] fin_load;
    logic [GW-1:0]    fin_dst   [NBANK];
    logic [DW-1:0]    fin_rdata [NBANK];
    logic [NREQ-1:0]  done_v;
    logic [NREQ-1:0]  load_acc;

    // Split the flat requester buses into per-requester fields.
    for (genvar i = 0; i < NREQ; i++) begin : g_req
        assign r_bank[i]  = req_bank[i*BW +: BW];
        assign r_row[i]   = req_row[i*RW +: RW];
        assign r_wdata[i] = req_wdata[i*DW +: DW];
        assign r_dst[i]   = req_dst[i*GW +: GW];
        assign rsp_rdata[i*DW +: DW] = r_rdata[i];
    end

    smp_arbiter #(.NREQ(NREQ), .NBANK(NBANK)) u_arb (
        .valid  (req_valid),
        .bank   (r_bank),
        .busy   (bank_busy),
        .accept (req_accept),
        .go     (go),
        .who    (who)
    );

    // One timer and storage array per bank, fed by that bank's winner.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        smp_bank_unit #(
            .NREQ(NREQ), .ROWS(ROWS), .DW(DW), .NREG(NREG), .LAT(LAT)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (go[b]),
            .st_who    (who[b]),
            .st_op     (op_e'(req_write[who[b]])),
            .st_row    (r_row[who[b]]),
            .st_wdata  (r_wdata[who[b]]),
            .st_dst    (r_dst[who[b]]),
            .busy      (bank_busy[b]),
            .fin       (fin[b]),
            .fin_who   (fin_who[b]),
            .fin_load  (fin_load[b]),
            .fin_dst   (fin_dst[b]),
            .fin_rdata (fin_rdata[b])
        );
    end

    // Route each bank completion back to the requester that owns it.
    always_comb begin
        for (int i = 0; i < NREQ; i++) begin
            done_v[i]  = 1'b0;
            r_rdata[i] = '0;
            for (int b = 0; b < NBANK; b++) begin
                if (fin[b] && (fin_who[b] == IW'(i))) begin
                    done_v[i]  = 1'b1;
                    r_rdata[i] = fin_rdata[b];
                end
            end
        end
    end

    assign rsp_done = done_v;
    assign busy     = |bank_busy;
    assign load_acc = req_accept & ~req_write;

    smp_pend_board #(.NREQ(NREQ), .NBANK(NBANK), .NREG(NREG)) u_board (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (load_acc),
        .set_idx   (r_dst),
        .clr_en    (fin_load),
        .clr_idx   (fin_dst),
        .chk_valid (chk_valid),
        .chk_src_a (chk_src_a),
        .chk_src_b (chk_src_b),
        .stall     (stall)
    );
endmodule

// File: rtl/smp_bank_sched_chk.sv
// Checker for the bank scheduler, attached with bind. It observes only the
// top-level ports and keeps its own per-requester accept history, sized by
// LAT, to check completion timing.
module smp_bank_sched_chk #(
    parameter int NREQ  = 4,
    parameter int NBANK = 4,
    parameter int LAT   = 5,
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NREQ-1:0]   req_valid,
    input logic [NREQ*BW-1:0] req_bank,
    input logic [NREQ-1:0]   req_accept,
    input logic [NREQ-1:0]   rsp_done,
    input logic [NBANK-1:0]  bank_busy,
    input logic              busy,
    input logic              chk_valid,
    input logic              stall
);
    for (genvar i = 0; i < NREQ; i++) begin : g_per_req
        logic [LAT-1:0] hist;

        // Shift in the accept history of this requester.
        always_ff @(posedge clk) begin
            if (!rst_n) hist <= '0;
            else        hist <= (hist << 1) | LAT'(req_accept[i]);
        end

        // R5: completion comes exactly LAT cycles after the accept.
        a_r5_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_done[i] == hist[LAT-1]);

        // R6: nothing is accepted into a bank that is still busy.
        a_r6_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
            req_accept[i] |-> !bank_busy[req_bank[i*BW +: BW]]);
    end

    // R4: requester 0 is always served at once when its bank is free.
    a_r4_top_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[0] && !bank_busy[req_bank[BW-1:0]]) |-> req_accept[0]);

    // R8: the summary busy follows the per-bank flags.
    a_r8_busy_any: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (bank_busy != '0));

    // R10: no stall without an instruction being checked.
    a_r10_no_check_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> !stall);
endmodule

bind smp_bank_sched smp_bank_sched_chk #(
    .NREQ(NREQ), .NBANK(NBANK), .LAT(LAT)
) u_chk (.*);

// File: tb/smp_bank_sched_tb.sv
// Bench for the bank scheduler: a behavioural model built from a queue of
// in-flight accesses, compared against every output on every clock.
module smp_bank_sched_tb;
    localparam int NREQ = 4, NBANK = 4, ROWS = 8, DW = 16, NREG = 8, LAT = 5;
    localparam int BW = 2, RW = 3, GW = 3;

    typedef struct {
        int due; int req; bit wr; int bank; int row; int data; int dst;
    } fl_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NREQ-1:0] v = '0;
    logic [NREQ-1:0] w = '0;
    logic [BW-1:0] bk  [NREQ];
    logic [RW-1:0] rw  [NREQ];
    logic [DW-1:0] wd  [NREQ];
    logic [GW-1:0] dst [NREQ];
    logic cv = 1'b0;
    logic [GW-1:0] ca = '0, cb = '0;

    logic [NREQ*BW-1:0] req_bank;
    logic [NREQ*RW-1:0] req_row;
    logic [NREQ*DW-1:0] req_wdata;
    logic [NREQ*GW-1:0] req_dst;
    logic [NREQ-1:0] req_accept, rsp_done;
    logic [NREQ*DW-1:0] rsp_rdata;
    logic [NBANK-1:0] bank_busy;
    logic busy, stall;

    for (genvar i = 0; i < NREQ; i++) begin : g_pack
        assign req_bank[i*BW +: BW]  = bk[i];
        assign req_row[i*RW +: RW]   = rw[i];
        assign req_wdata[i*DW +: DW] = wd[i];
        assign req_dst[i*GW +: GW]   = dst[i];
    end

    always #10 clk = ~clk;

    smp_bank_sched u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(v), .req_write(w),
        .req_bank(req_bank), .req_row(req_row), .req_wdata(req_wdata),
        .req_dst(req_dst), .req_accept(req_accept), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .bank_busy(bank_busy), .busy(busy),
        .chk_valid(cv), .chk_src_a(ca), .chk_src_b(cb), .stall(stall)
    );

    int total = 0, bad = 0, cyc = 0;
    int mem [NBANK][ROWS];
    bit pend [NREG];
    fl_t fq[$];

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s cyc=%0d act=%0d exp=%0d", tag, cyc, act, exp);
        end
    endtask

    task automatic put(int i, bit wr, int b, int r, int d, int g);
        v[i] = 1'b1; w[i] = wr; bk[i] = BW'(b); rw[i] = RW'(r);
        wd[i] = DW'(d); dst[i] = GW'(g);
    endtask

    // One cycle: predict, compare, advance the model, cross the clock edge.
    task automatic step();
        bit eb [NBANK];
        int ea [NREQ], ed [NREQ], er [NREQ];
        int es, win;
        fl_t keep[$];
        fl_t f;
        #2;
        for (int b = 0; b < NBANK; b++) begin
            eb[b] = 0;
            foreach (fq[k]) if (fq[k].bank == b) eb[b] = 1;
        end
        for (int i = 0; i < NREQ; i++) begin ea[i] = 0; ed[i] = 0; er[i] = 0; end
        for (int b = 0; b < NBANK; b++) begin
            win = -1;
            if (!eb[b])
                for (int i = 0; i < NREQ; i++)
                    if (v[i] && int'(bk[i]) == b && win < 0) win = i;
            if (win >= 0) ea[win] = 1;
        end
        foreach (fq[k]) if (fq[k].due == cyc) begin
            ed[fq[k].req] = 1;
            er[fq[k].req] = fq[k].wr ? 0 : mem[fq[k].bank][fq[k].row];
        end
        es = int'(cv && (pend[ca] || pend[cb]));
        for (int i = 0; i < NREQ; i++) begin
            chk("R2 R3 R4 accept", int'(req_accept[i]), ea[i]);
            chk("R5 done", int'(rsp_done[i]), ed[i]);
            chk("R7 rdata", int'(rsp_rdata[i*DW +: DW]), er[i]);
        end
        for (int b = 0; b < NBANK; b++) chk("R6 bank_busy", int'(bank_busy[b]), int'(eb[b]));
        chk("R8 busy", int'(busy), int'(eb[0] | eb[1] | eb[2] | eb[3]));
        chk("R9 R10 R11 stall", int'(stall), es);
        foreach (fq[k]) begin
            if (fq[k].due == cyc) begin
                if (fq[k].wr) mem[fq[k].bank][fq[k].row] = fq[k].data;
                else pend[fq[k].dst] = 0;
            end else keep.push_back(fq[k]);
        end
        fq = keep;
        for (int i = 0; i < NREQ; i++) if (ea[i] != 0) begin
            f.due = cyc + LAT; f.req = i; f.wr = w[i]; f.bank = int'(bk[i]);
            f.row = int'(rw[i]); f.data = int'(wd[i]); f.dst = int'(dst[i]);
            fq.push_back(f);
            if (!w[i]) pend[dst[i]] = 1;
        end
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NREQ; i++) if (ea[i] != 0) v[i] = 1'b0;
        cyc++;
    endtask

    task automatic run_until_idle();
        while (v != '0) step();
        repeat (LAT + 1) step();
    endtask

    initial begin
        #4000000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREQ; i++) begin bk[i] = '0; rw[i] = '0; wd[i] = '0; dst[i] = '0; end
        for (int b = 0; b < NBANK; b++) for (int r = 0; r < ROWS; r++) mem[b][r] = 0;
        for (int g = 0; g < NREG; g++) pend[g] = 0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet while held in reset
        chk("R1 accept", int'(req_accept), 0);
        chk("R1 done", int'(rsp_done), 0);
        chk("R1 bank_busy", int'(bank_busy), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 stall", int'(stall), 0);
        rst_n = 1'b1;
        // R1: loads before any store read zero
        put(0, 0, 2, 5, 0, 1);
        run_until_idle();

        // R3 R6: four loads collide on bank 0
        for (int i = 0; i < NREQ; i++) put(i, 0, 0, i + 1, 0, i);
        run_until_idle();

        // R2: four stores to four banks at once, then read back (R7)
        for (int i = 0; i < NREQ; i++) put(i, 1, i, 3, 16'h1000 + i * 7, 0);
        run_until_idle();
        for (int i = 0; i < NREQ; i++) put(i, 0, NREQ - 1 - i, 3, 0, i);
        run_until_idle();

        // R9: load to reg 3, second load to reg 3 lands in the first one's done cycle
        cv = 1'b1; ca = 3'd3; cb = 3'd0;
        put(0, 0, 0, 3, 0, 3);
        step();
        repeat (LAT - 1) step();
        put(1, 0, 1, 3, 0, 3);
        run_until_idle();

        // R11: a store with destination 5 never stalls a reader of reg 5
        ca = 3'd5; cb = 3'd5;
        put(2, 1, 2, 6, 16'hbeef, 5);
        run_until_idle();

        // R10: pending load but no instruction checked
        put(3, 0, 3, 6, 0, 6);
        cv = 1'b0; ca = 3'd6;
        run_until_idle();

        // Mixed traffic on all ports
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < NREQ; i++)
                if (!v[i] && $urandom_range(2) == 0)
                    put(i, 1'($urandom_range(1)), $urandom_range(NBANK - 1),
                        $urandom_range(ROWS - 1), $urandom_range(65535),
                        $urandom_range(NREG - 1));
            cv = 1'($urandom_range(1));
            ca = GW'($urandom_range(NREG - 1));
            cb = GW'($urandom_range(NREG - 1));
            step();
        end
        v = '0;
        repeat (LAT + 2) step();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule